// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block sits beside a DMA channel and cuts the interrupt rate seen by the processor. The engine sends it a one-cycle pulse for each finished descriptor and a one-cycle pulse for each error. Completion pulses are counted down from a programmable group size. When the count would reach zero, a completion status bit is set and the counter reloads, so the next group starts at once.

A delay timer covers the tail of a transfer. Some events may be counted but the group may still be short. If no further completion arrives within a programmed number of cycles, a delay status bit is set and the partial group is treated as reported.

The three status bits are sticky and are cleared by writing ones to them. A single interrupt line is the OR of the status bits whose enables are set. Software programs everything through one 32-bit control word.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `sts_o` is 0, `irq_o` is low, `cnt_o` is 1 (group size 1), the delay limit is 0 and all three enables are off.
- R2: A control write (`cfg_we_i`) places fields as follows: the group size is bits [23:16], the delay limit is bits [31:24], the completion enable is bit 12, the delay enable is bit 13 and the error enable is bit 14. The limit and all three enables take effect on every write.
- R3: A control write whose bits [23:16] are zero leaves both the stored group size and `cnt_o` unchanged. The other fields are still written.
- R4: A control write with a nonzero group size reloads `cnt_o` to that value on the next cycle. A completion pulse in the same cycle is applied after the reload, so a new size N gives N-1, and a new size 1 counts as a full group.
- R5: Each completion pulse lowers `cnt_o` by one. When the pulse would take the count to zero, status bit 0 (completion) is set and `cnt_o` reloads to the group size.
- R6: While the delay enable is set and events are pending (`cnt_o` differs from the group size), status bit 1 (delay) is set at the (L+1)th clock edge after the last completion pulse, where L is the delay limit. `cnt_o` reloads to the group size at the same edge. Every completion pulse restarts this wait.
- R7: While the delay enable is clear, status bit 1 is never set and pending events stay pending.
- R8: An error pulse (`err_evt_i`) sets status bit 2 on the next edge, whatever the state of its enable.
- R9: With `sts_clr_we_i` high, each one in `sts_clr_i` clears the matching status bit. If a bit is set and cleared in the same cycle, the set wins. Status bits otherwise hold.
- R10: `irq_o` is high exactly when some status bit is set and its enable is on. Bit 0 pairs with the completion enable, bit 1 with the delay enable and bit 2 with the error enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word: group size, delay limit, enables |
| done_evt_i | input | 1 | One-cycle descriptor completion pulse |
| err_evt_i | input | 1 | One-cycle error pulse |
| sts_clr_we_i | input | 1 | Status clear strobe |
| sts_clr_i | input | 3 | Write-one-to-clear mask (bit 0 completion, 1 delay, 2 error) |
| irq_o | output | 1 | Interrupt request |
| sts_o | output | 3 | Sticky status bits |
| cnt_o | output | 8 | Events left before the group completes |

## Verification
The collisions that matter are a group-size write that lands in the same cycle as a completion pulse, and a status clear that lands in the same cycle as the event that sets the same bit. Directed sequences place the write or the clear exactly on the event cycle with group sizes 1 and above 1. The outcomes are judged against R4 (reload first, then count) and R9 (set beats clear). A long random phase also makes these collisions occur freely against a behavioural model compared on every clock.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
  localparam int STS_W       = 3;
  localparam int SB_DONE     = 0;
  localparam int SB_DLY      = 1;
  localparam int SB_ERR      = 2;
  localparam int THR_LSB     = 16;
  localparam int LIM_LSB     = 24;
  localparam int IE_DONE_BIT = 12;
  localparam int IE_DLY_BIT  = 13;
  localparam int IE_ERR_BIT  = 14;
endpackage

// File: rtl/irq_thr_counter.sv
module irq_thr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_wr_i,
  input  logic [CNT_W-1:0] thr_new_i,
  input  logic             evt_i,
  input  logic             flush_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] thr_q, cnt_q, thr_nxt, base;

  assign thr_nxt = thr_wr_i ? thr_new_i : thr_q;
  // a size write reloads first; a same-cycle event counts from the new size
  assign base    = thr_wr_i ? thr_new_i : cnt_q;
  assign hit_o   = evt_i && (base == ONE);
  assign pend_o  = (cnt_q != thr_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= ONE;
      cnt_q <= ONE;
    end else begin
      thr_q <= thr_nxt;
      if (evt_i)                    cnt_q <= hit_o ? thr_nxt : base - ONE;
      else if (thr_wr_i || flush_i) cnt_q <= thr_nxt;
    end
  end
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             arm_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] tmr_q;

  assign fire_o = arm_i && !restart_i && (tmr_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tmr_q <= '0;
    else if (restart_i || fire_o)  tmr_q <= '0;
    else if (tmr_q != limit_i)     tmr_q <= tmr_q + DLY_W'(1);
  end
endmodule

// File: rtl/irq_sts_regs.sv
module irq_sts_regs #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[i] <= 1'b0;
      else if (set_i[i]) sts_q[i] <= 1'b1;
      else if (clr_i[i]) sts_q[i] <= 1'b0;
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coalesce_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              done_evt_i,
  input  logic              err_evt_i,
  input  logic              sts_clr_we_i,
  input  logic [STS_W-1:0]  sts_clr_i,
  output logic              irq_o,
  output logic [STS_W-1:0]  sts_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] thr_fld;
  logic             thr_wr, hit, pend, fire, restart;
  logic [DLY_W-1:0] lim_q;
  logic [STS_W-1:0] ie_q, set_v, clr_v;

  assign thr_fld = cfg_wdata_i[THR_LSB +: CNT_W];
  assign thr_wr  = cfg_we_i && (thr_fld != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      ie_q  <= '0;
    end else if (cfg_we_i) begin
      lim_q        <= cfg_wdata_i[LIM_LSB +: DLY_W];
      ie_q[SB_DONE] <= cfg_wdata_i[IE_DONE_BIT];
      ie_q[SB_DLY]  <= cfg_wdata_i[IE_DLY_BIT];
      ie_q[SB_ERR]  <= cfg_wdata_i[IE_ERR_BIT];
    end
  end

  irq_thr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_wr_i  (thr_wr),
    .thr_new_i (thr_fld),
    .evt_i     (done_evt_i),
    .flush_i   (fire),
    .cnt_o     (cnt_o),
    .hit_o     (hit),
    .pend_o    (pend)
  );

  // wait restarts on each event, on a reload, and while nothing is pending
  assign restart = done_evt_i || thr_wr || !pend;

  irq_delay_timer #(.DLY_W(DLY_W)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .arm_i     (ie_q[SB_DLY]),
    .limit_i   (lim_q),
    .fire_o    (fire)
  );

  always_comb begin
    set_v          = '0;
    set_v[SB_DONE] = hit;
    set_v[SB_DLY]  = fire;
    set_v[SB_ERR]  = err_evt_i;
  end
  assign clr_v = sts_clr_we_i ? sts_clr_i : '0;

  irq_sts_regs #(.N(STS_W)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .sts_o  (sts_o)
  );

  assign irq_o = |(sts_o & ie_q);
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk
  import irq_coalesce_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic              done_evt_i,
  input logic              err_evt_i,
  input logic              sts_clr_we_i,
  input logic [STS_W-1:0]  sts_clr_i,
  input logic              irq_o,
  input logic [STS_W-1:0]  sts_o,
  input logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] fld;
  assign fld = cfg_wdata_i[THR_LSB +: CNT_W];

  a_r5_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o != '0);

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_i && !cfg_we_i && (cnt_o > CNT_W'(1)) |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (fld != '0) && !done_evt_i |=> cnt_o == $past(fld));

  a_r3_zero_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (fld == '0) && !done_evt_i |=> ($stable(cnt_o) || sts_o[SB_DLY]));

  a_r8_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> sts_o[SB_ERR]);

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[SB_DONE] && !(sts_clr_we_i && sts_clr_i[SB_DONE]) |=> sts_o[SB_DONE]);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_clr_we_i && sts_clr_i[SB_ERR] && !err_evt_i |=> !sts_o[SB_ERR]);

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o == '0) |-> !irq_o);
endmodule

bind irq_coalesce irq_coalesce_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .done_evt_i   (done_evt_i),
  .err_evt_i    (err_evt_i),
  .sts_clr_we_i (sts_clr_we_i),
  .sts_clr_i    (sts_clr_i),
  .irq_o        (irq_o),
  .sts_o        (sts_o),
  .cnt_o        (cnt_o)
);

// File: tb/irq_coalesce_tb_top.sv
module irq_coalesce_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, done = 1'b0, err = 1'b0, cwe = 1'b0;
  logic [31:0] wd = '0;
  logic [2:0]  cv = '0;
  logic        irq;
  logic [2:0]  sts;
  logic [7:0]  cnt;

  always #5 clk = ~clk;

  irq_coalesce dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd),
    .done_evt_i(done), .err_evt_i(err), .sts_clr_we_i(cwe), .sts_clr_i(cv),
    .irq_o(irq), .sts_o(sts), .cnt_o(cnt)
  );

  int    n_run = 0, n_fail = 0;
  string tag = "R1";

  task automatic chk(string t, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference
  int       m_thr = 1, m_cnt = 1, m_tmr = 0, m_lim = 0;
  bit [2:0] m_ie = 0, m_sts = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thr = 1; m_cnt = 1; m_tmr = 0; m_lim = 0; m_ie = 0; m_sts = 0;
    end else begin
      int       f, nthr, base;
      bit       twr, restart, fire;
      bit [2:0] set;
      f       = wd[23:16];
      twr     = we && f != 0;
      nthr    = twr ? f : m_thr;
      restart = done || twr || (m_cnt == m_thr);
      fire    = m_ie[1] && !restart && m_tmr == m_lim;
      set     = 0;
      if (done) begin
        base = twr ? f : m_cnt;
        if (base == 1) begin set[0] = 1; m_cnt = nthr; end
        else m_cnt = base - 1;
      end else if (twr || fire) m_cnt = nthr;
      m_thr = nthr;
      if (fire) set[1] = 1;
      if (err)  set[2] = 1;
      if (restart || fire) m_tmr = 0;
      else if (m_tmr != m_lim) m_tmr = (m_tmr + 1) % 256;
      m_sts = (m_sts & ~(cwe ? cv : 3'b0)) | set;
      if (we) begin
        m_lim = wd[31:24];
        m_ie  = {wd[14], wd[13], wd[12]};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " sts"}, sts, m_sts);
      chk({tag, " cnt"}, cnt, m_cnt);
      chk({tag, " irq"}, irq, |(m_sts & m_ie));
    end
  end

  function automatic logic [31:0] mk(int thr, int lim, bit de, bit le, bit ee);
    return {lim[7:0], thr[7:0], 1'b0, ee, le, de, 12'h000};
  endfunction

  task automatic cyc(bit w, logic [31:0] d, bit e, bit r, bit c, logic [2:0] m);
    @(posedge clk); #1;
    we = w; wd = d; done = e; err = r; cwe = c; cv = m;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, '0);
  endtask

  task automatic evt();
    cyc(0, '0, 1, 0, 0, '0);
  endtask

  task automatic cfg(logic [31:0] d);
    cyc(1, d, 0, 0, 0, '0);
  endtask

  task automatic clr(logic [2:0] m);
    cyc(0, '0, 0, 0, 1, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    tag = "R1";
    chk("R1 sts", sts, 0); chk("R1 irq", irq, 0); chk("R1 cnt", cnt, 1);

    tag = "R5";
    cfg(mk(3, 0, 1, 0, 0)); idle(1);
    chk("R2 size", cnt, 3);
    evt(); evt(); idle(1);
    chk("R5 cnt", cnt, 1); chk("R5 no done", sts[0], 0);
    evt(); idle(1);
    chk("R5 done", sts[0], 1); chk("R5 reload", cnt, 3); chk("R10 irq", irq, 1);

    tag = "R9";
    clr(3'b001); idle(1);
    chk("R9 cleared", sts[0], 0); chk("R10 irq low", irq, 0);
    cfg(mk(1, 0, 1, 0, 0)); evt(); cyc(0, '0, 1, 0, 1, 3'b001); idle(1);
    chk("R9 set wins", sts[0], 1);
    clr(3'b111); idle(1);

    tag = "R3";
    cfg(mk(4, 0, 1, 0, 0)); evt(); idle(1);
    chk("R3 pre", cnt, 3);
    cfg(mk(0, 0, 0, 0, 1)); idle(1);
    chk("R3 cnt kept", cnt, 3);
    evt(); evt(); idle(1);
    chk("R3 size kept", cnt, 1);
    tag = "R8";
    cyc(0, '0, 0, 1, 0, '0); idle(1);
    chk("R8 err", sts[2], 1); chk("R10 err irq", irq, 1);
    clr(3'b100); idle(1);

    tag = "R4";
    evt(); cyc(1, mk(6, 0, 0, 0, 1), 1, 0, 0, '0); idle(1);
    chk("R4 reload then count", cnt, 5);
    clr(3'b111); cyc(1, mk(1, 0, 1, 0, 0), 1, 0, 0, '0); idle(1);
    chk("R4 size one hit", sts[0], 1); chk("R4 cnt", cnt, 1);
    clr(3'b111); idle(1);

    tag = "R6";
    cfg(mk(5, 4, 0, 1, 0)); evt(); idle(5);
    chk("R6 not yet", sts[1], 0);
    idle(1);
    chk("R6 fired", sts[1], 1); chk("R6 reload", cnt, 5); chk("R10 dly irq", irq, 1);
    clr(3'b010); evt(); idle(3); evt(); idle(5);
    chk("R6 restart", sts[1], 0); chk("R6 pending", cnt, 3);
    idle(1);
    chk("R6 fired again", sts[1], 1);
    clr(3'b111);

    tag = "R7";
    cfg(mk(5, 2, 0, 0, 0)); evt(); idle(20);
    chk("R7 no delay", sts[1], 0); chk("R7 pending", cnt, 4);

    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 6, {$urandom} & 32'hFFFF_7000, $urandom_range(0, 2) == 0,
          $urandom_range(0, 30) == 0, $urandom_range(0, 8) == 0, 3'($urandom));
      if (r < 2) cfg(mk(0, 3, 1, 1, 1));
    end
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule